// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses the direction of conditional branches at fetch time. It keeps a short global record of the most recent resolved branch outcomes. That record is joined with a few low bits of the branch address to pick one 2-bit saturating counter out of a single flat table. The result is that the same branch can hold a separate prediction for each recent-outcome pattern. When two branches in a row are linked, the second one is predicted from what the first one actually did.

The fetch side presents an instruction address on the lookup port. It receives a taken or not-taken guess in the same cycle, with no clock edge in between. The execute side reports each resolved branch on the update port. In that cycle the selected counter is trained, and at the clock edge the outcome is shifted into the history.

The table carries no address tags. Branches that share index bits and history therefore share a counter. The table depth is set by the history length and the number of address bits used for the index.

Top module: `corr_bpred`

## Requirements
- R1: After reset, every counter holds 1 (weakly not taken) and the history holds 0, so every lookup predicts not taken until the first update.
- R2: A lookup predicts taken (lk_taken = 1) when the selected counter is 2 or 3. It predicts not taken when the counter is 0 or 1.
- R3: An update moves the selected counter up by one for a taken outcome and down by one for a not-taken outcome. The counter stays at 3 when it is already at 3 and stays at 0 when it is already at 0.
- R4: The table index is {history, pc[PC_IDX_W+1:2]}, with the history in the upper bits. Address bits [1:0] and the bits above PC_IDX_W+1 are ignored, so addresses that agree in the index bits share an entry.
- R5: Each update shifts the history left by one and places the new outcome (1 = taken) in bit 0.
- R6: An update trains the entry selected by up_pc and the history as it stands before that update's shift.
- R7: A lookup in the same cycle as an update to the same entry returns the counter value from before the update. The new value is visible from the next cycle.
- R8: While up_valid is low, up_pc and up_taken have no effect on any counter or on the history.
- R9: A counter at 3 still predicts taken after one not-taken update to it. Only a second not-taken update to the same entry turns its prediction to not taken.
- R10: Driving rst_n low returns all predictions to not taken at once, without waiting for a clock edge. Release of the reset is synchronised to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_pc | input | ADDR_W | Fetch address to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The hardest case to reach is observing one counter twice under the same history. Every update moves the history, so training an entry and then reading it back normally lands on a different entry. The stimulus solves this by interleaving updates on a second address whose outcomes steer the history back to the wanted pattern. It uses this to show hysteresis on a strongly taken entry and to show the ordering of history bits. A behavioural table model in the bench follows every update and supplies expected predictions for a long pseudo-random run. In that run, lookup and update addresses differ, address offset bits are scrambled and gaps without updates are mixed in.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;

  typedef logic [1:0] ctr2_t;

  // weakly not taken
  localparam ctr2_t CTR_INIT = 2'd1;
  localparam ctr2_t CTR_MAX  = 2'd3;
  localparam ctr2_t CTR_MIN  = 2'd0;

  // one saturating training step
  function automatic ctr2_t ctr_train(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_MAX) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_MIN) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  // upper half of the range predicts taken
  function automatic logic ctr_predict(input ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/corr_bp_rst_sync.sv
module corr_bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/corr_bp_ghr.sv
module corr_bp_ghr #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_shift;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      always_comb begin
        hist_shift = upd_taken;
      end
    end else begin : g_many
      always_comb begin
        hist_shift = {hist_q[HIST_W-2:0], upd_taken};
      end
    end
  endgenerate

  always_comb begin
    hist_d = hist_q;
    if (upd_en) hist_d = hist_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign hist = hist_q;

  // R5
  ghr_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> hist_q[0] == $past(upd_taken));

  // R8
  ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(hist_q));

endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table
  import corr_bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int NUM_ENT = 1 << IDX_W;

  ctr2_t ctr_q [NUM_ENT];
  ctr2_t wr_old;
  ctr2_t wr_new;

  always_comb begin
    wr_old = ctr_q[wr_idx];
    wr_new = ctr_train(wr_old, wr_taken);
  end

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      logic  sel;
      ctr2_t q;
      ctr2_t d;

      always_comb begin
        sel = wr_en && (wr_idx == IDX_W'(g));
        d   = q;
        if (sel) d = wr_new;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= CTR_INIT;
        end else begin
          q <= d;
        end
      end

      assign ctr_q[g] = q;
    end
  endgenerate

  assign rd_ctr = ctr_q[rd_idx];

  // R3
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken) |=>
      ctr_q[$past(wr_idx)] == (($past(wr_old) == CTR_MAX) ? CTR_MAX : $past(wr_old) + 2'd1));

  // R3
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken) |=>
      ctr_q[$past(wr_idx)] == (($past(wr_old) == CTR_MIN) ? CTR_MIN : $past(wr_old) - 2'd1));

  // R9
  ctr_hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old == CTR_MAX) |=> ctr_q[$past(wr_idx)][1]);

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import corr_bp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 2,
  parameter int PC_IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken
);

  localparam int IDX_W  = HIST_W + PC_IDX_W;
  localparam int PC_LSB = 2;
  localparam int PC_MSB = PC_LSB + PC_IDX_W - 1;

  logic              rst_int_n;
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  ctr2_t             rd_ctr;

  corr_bp_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  corr_bp_ghr #(
    .HIST_W (HIST_W)
  ) u_ghr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd_en    (up_valid),
    .upd_taken (up_taken),
    .hist      (hist)
  );

  always_comb begin
    rd_idx = {hist, lk_pc[PC_MSB:PC_LSB]};
    wr_idx = {hist, up_pc[PC_MSB:PC_LSB]};
  end

  corr_bp_table #(
    .IDX_W (IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (up_valid),
    .wr_idx   (wr_idx),
    .wr_taken (up_taken)
  );

  assign lk_taken = ctr_predict(rd_ctr);

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[ADDR_W-1:PC_MSB+1], lk_pc[PC_LSB-1:0],
                            up_pc[ADDR_W-1:PC_MSB+1], up_pc[PC_LSB-1:0]};

  // R8
  idle_pred_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!up_valid ##1 $stable(lk_pc)) |-> $stable(lk_taken));

endmodule

// File: tb/corr_bpred_tb.sv
`timescale 1ns/1ps
module corr_bpred_tb;

  localparam int AW  = 32;
  localparam int HW  = 2;
  localparam int PW  = 6;
  localparam int NUM = 1 << (HW + PW);

  // per step: {outcome, expected prediction}, all on address 0x100
  localparam logic [1:0] VEC [10] = '{
    2'b10, 2'b10, 2'b10, 2'b11, 2'b01,
    2'b00, 2'b01, 2'b00, 2'b00, 2'b10
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] lk_pc;
  logic          lk_taken;
  logic          up_valid;
  logic [AW-1:0] up_pc;
  logic          up_taken;

  always #2.5 clk = ~clk;

  corr_bpred #(
    .ADDR_W   (AW),
    .HIST_W   (HW),
    .PC_IDX_W (PW)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_pc    (up_pc),
    .up_taken (up_taken)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int mdl [NUM];
  int mghr;

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM; i++) mdl[i] = 1;
    mghr = 0;
  endtask

  function automatic int midx(input logic [AW-1:0] pc);
    return ((mghr & ((1 << HW) - 1)) << PW) | int'((pc >> 2) & ((1 << PW) - 1));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    up_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  // drive one cycle, check prediction against the model, then advance the model
  task automatic mstep(input logic [AW-1:0] lpc, input logic [AW-1:0] upc,
                       input logic v, input logic t, input string req);
    int ui;
    @(negedge clk);
    lk_pc    = lpc;
    up_pc    = upc;
    up_valid = v;
    up_taken = t;
    #1;
    check(req, lk_taken, mdl[midx(lpc)] >= 2);
    if (v) begin
      ui = midx(upc);
      if (t && mdl[ui] < 3) mdl[ui]++;
      if (!t && mdl[ui] > 0) mdl[ui]--;
      mghr = ((mghr << 1) | int'(t)) & ((1 << HW) - 1);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n    = 1'b0;
    lk_pc    = '0;
    up_pc    = '0;
    up_valid = 1'b0;
    up_taken = 1'b0;
    model_reset();

    // R1: reset state predicts not taken everywhere
    do_reset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lk_pc = AW'(i * 36 + 4);
      #1;
      check("R1", lk_taken, 1'b0);
    end

    // R2 R3 R7: hand-computed vector walk on one address
    do_reset();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      lk_pc    = 32'h100;
      up_pc    = 32'h100;
      up_valid = 1'b1;
      up_taken = VEC[i][1];
      #1;
      check("R2/R3/R7 vector", lk_taken, VEC[i][0]);
    end

    // R7: after the update above the new value shows next cycle
    // history is now 01 and entry (01,0x100) was trained to 2
    @(negedge clk);
    up_valid = 1'b0;
    lk_pc    = 32'h100;
    #1;
    check("R7", lk_taken, 1'b1);

    // R9: hysteresis on entry (11, B) using C to steer history back to 11
    do_reset();
    for (int i = 0; i < 4; i++) mstep(32'h40, 32'h40, 1'b1, 1'b1, "R9 train");
    // entry (11,B) now 3
    mstep(32'h40, 32'h40, 1'b1, 1'b0, "R9 first NT");
    mstep(32'h80, 32'h80, 1'b1, 1'b1, "R9 steer");
    mstep(32'h80, 32'h80, 1'b1, 1'b1, "R9 steer");
    @(negedge clk);
    up_valid = 1'b0;
    lk_pc    = 32'h40;
    #1;
    check("R9 still taken after one NT", lk_taken, 1'b1);
    mstep(32'h40, 32'h40, 1'b1, 1'b0, "R9 second NT");
    mstep(32'h80, 32'h80, 1'b1, 1'b1, "R9 steer");
    mstep(32'h80, 32'h80, 1'b1, 1'b1, "R9 steer");
    @(negedge clk);
    up_valid = 1'b0;
    lk_pc    = 32'h40;
    #1;
    check("R9 flips after two NT", lk_taken, 1'b0);

    // R4: aliasing through ignored upper and offset bits
    do_reset();
    mstep(32'h104, 32'h104, 1'b1, 1'b0, "R4 setup");
    mstep(32'h104, 32'h104, 1'b1, 1'b0, "R4 setup");
    mstep(32'h104, 32'h104, 1'b1, 1'b1, "R4 setup");
    // history 01; train (01, idx1) via an alias
    mstep(32'h104, 32'h8000_0107, 1'b1, 1'b0, "R4 alias update");
    // history 10; entry (01,idx1) = 0, (10,idx1) = 1
    mstep(32'h104, 32'h104, 1'b1, 1'b1, "R4");
    mstep(32'hFFFF_FF05, 32'h104, 1'b0, 1'b0, "R4 alias lookup");
    @(negedge clk);
    lk_pc = 32'h0000_0306;
    #1;
    check("R4 other index", lk_taken, mdl[midx(32'h306)] >= 2);

    // R5: history order T then NT gives 10, distinguishes from 01
    do_reset();
    mstep(32'h200, 32'h200, 1'b1, 1'b1, "R5");
    mstep(32'h200, 32'h200, 1'b1, 1'b0, "R5");
    mstep(32'h200, 32'h200, 1'b1, 1'b1, "R5 train (10,D)");
    mstep(32'h300, 32'h300, 1'b1, 1'b0, "R5");
    // history back to 10, entry (10,D) = 2
    @(negedge clk);
    up_valid = 1'b0;
    lk_pc    = 32'h200;
    #1;
    check("R5 history order", lk_taken, 1'b1);

    // R8: updates with valid low change nothing
    for (int i = 0; i < 8; i++) mstep(32'h200, 32'h200, 1'b0, i[0], "R8 idle");
    mstep(32'h200, 32'h200, 1'b0, 1'b1, "R8");
    mstep(32'h300, 32'h300, 1'b1, 1'b1, "R8 after idle");
    mstep(32'h200, 32'h200, 1'b1, 1'b1, "R8 after idle");

    // R10: asynchronous reset clears predictions before any edge
    @(negedge clk);
    up_valid = 1'b0;
    lk_pc    = 32'h200;
    #1;
    check("R10 pre", lk_taken, mdl[midx(32'h200)] >= 2);
    mstep(32'h200, 32'h200, 1'b1, 1'b1, "R10 pre");
    mstep(32'h200, 32'h200, 1'b1, 1'b1, "R10 pre");
    @(negedge clk);
    up_valid = 1'b0;
    lk_pc    = 32'h200;
    #0.5;
    check("R10 trained", lk_taken, 1'b1);
    rst_n = 1'b0;
    #0.5;
    check("R10 async clear", lk_taken, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();

    // R6: pseudo-random run against the model
    lf = 32'h1ACE_5EED;
    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a  = {lf[31:24], 16'h0, 2'b0, lf[5:3], 3'b0, lf[1:0]};
      b  = lf[8] ? a : {lf[23:16], 16'h0, 2'b0, lf[11:9], 3'b0, lf[13:12]};
      mstep(a, b, lf[14] | lf[15], lf[16] | (lf[17] & lf[3]), "R6 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule